// File: doc/BRIEF.md
# Programmable ROM Read Timing Sequencer

This block runs the read cycles of an asynchronous ROM or flash device for a memory controller. A requester presents a start address, a beat count and a target memory space. The block then drives the address, one active-low chip select per space and a shared active-low output enable. It raises a one-clock capture strobe at the end of each beat's latency, so that the controller latches the data bus. When the access is over it pulses `done`.

Every memory space has its own timing slot. Each slot holds four fields: a first-beat latency, a burst-beat latency, a bus-release recovery count and a device code. The device code selects a plain device, a page-burst device of 4 words or a page-burst device of 8 words. On a page-burst device, only the beat that opens each device page waits the long latency. The beats after it wait the short one, and the low address bits wrap inside the page.

After an access, a request to a different space is held off until the slot's recovery count has run out. This gives the previous device time to stop driving the shared data bus. A request to the same space is not held off.

Top module: `rom_read_seq`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, every chip select and the output enable are high, `cap_stb` and `done` are low, and `req_ready` is high.
- R2: When `req_valid` and `req_ready` are both high at a clock edge, the request is accepted. From the next cycle, `mem_addr` holds the start address and only chip select `mem_cs_n[req_cs]` is low. `mem_oe_n` is low, and both selects stay asserted until the access ends.
- R3: Beat 0 of every access lasts F+1 clocks, where F is the first-beat latency field. `cap_stb` is high only in the last of those clocks.
- R4: For device code 0, and for every code other than 2 and 3, each beat lasts F+1 clocks. The address steps by one after each beat across its full width.
- R5: For device code 2 (page of 4), a beat whose index modulo 4 is 0 lasts F+1 clocks. Every other beat lasts B+1 clocks, where B is the burst-beat latency field. Address bits [1:0] step by one after each beat and wrap, and the upper bits are held.
- R6: For device code 3 (page of 8), a beat whose index modulo 8 is 0 lasts F+1 clocks and the others last B+1 clocks. Address bits [2:0] step and wrap, and the upper bits are held.
- R7: In the clock after the last strobe, `done` is high for one clock. In that same clock `mem_oe_n` and all chip selects are high again. Exactly one strobe is produced per beat.
- R8: After an access that ends with `done` in cycle D, a request to a different space sees `req_ready` low from D up to but not including D+R. Here R is the recovery field of the finished access. A request to the same space sees `req_ready` high in D.
- R9: The configuration fields are sampled when the request is accepted. Changing any of them during an access alters neither the beat timing nor the addresses.
- R10: A beat count of 0 is performed as a single beat.
- R11: The four timing fields are taken from the slot indexed by `req_cs`. Slot k occupies bits [k*W +: W] of each configuration bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | ADDR_W | Start word address |
| req_beats | input | BEAT_W | Number of beats (0 means 1) |
| req_cs | input | CS_W | Target memory space index |
| cfg_first_lat | input | NCS*LAT_W | Per-space first-beat latency |
| cfg_burst_lat | input | NCS*LAT_W | Per-space burst-beat latency |
| cfg_recover | input | NCS*REC_W | Per-space bus-release recovery count |
| cfg_dev_type | input | NCS*3 | Per-space device code (0 plain, 2 page-4, 3 page-8) |
| mem_addr | output | ADDR_W | Device address |
| mem_cs_n | output | NCS | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| cap_stb | output | 1 | One-clock data capture strobe per beat |
| done | output | 1 | Access complete pulse |

## Verification
The bench builds the block with two spaces, 8-bit addresses, 3-bit latency and recovery fields and 4-bit beat counts. At that size it can sweep every first/burst latency pair from 0 to 3 against four device codes and five beat counts. The beat counts include 0 and transfers that cross a 4-word and an 8-word page. Because the bench alternates the target space in runs and varies the recovery count from 0 to 7, both the held-off path and the same-space path of the recovery logic are exercised. The configuration buses are inverted immediately after each acceptance to show that the sampled copy is the one that governs the access.

// File: rtl/rom_seq_pkg.sv
// Shared constants and helpers for the ROM read sequencer.
// Assumes device codes are 3 bits wide; unknown codes behave as plain devices.
package rom_seq_pkg;

    localparam int DEV_CODE_W = 3;
    localparam logic [DEV_CODE_W-1:0] DEV_PLAIN = 3'd0;
    localparam logic [DEV_CODE_W-1:0] DEV_PAGE4 = 3'd2;
    localparam logic [DEV_CODE_W-1:0] DEV_PAGE8 = 3'd3;

    // True when the beat index opens a device page and needs the long latency.
    function automatic logic opens_page(input logic [DEV_CODE_W-1:0] code,
                                        input logic [2:0] idx_lo);
        case (code)
            DEV_PAGE4: opens_page = (idx_lo[1:0] == 2'd0);
            DEV_PAGE8: opens_page = (idx_lo == 3'd0);
            default:   opens_page = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/rom_beat_timer.sv
// Down-counter that times one beat and marks its final clock with a strobe.
// Assumes a load arrives in the cycle before each beat begins; idle when run is low.
module rom_beat_timer #(
    parameter int LAT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [LAT_W-1:0] load_val,
    output logic             stb
);
    logic [LAT_W-1:0] cnt_q;

    // Load the wait for the next beat, otherwise count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign stb = run && (cnt_q == '0);
endmodule

// File: rtl/rom_addr_step.sv
// Holds the device address and advances it once per beat.
// Assumes ADDR_W > 3; page devices wrap their low bits, plain devices count freely.
module rom_addr_step
    import rom_seq_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [ADDR_W-1:0]     load_addr,
    input  logic                  step,
    input  logic [DEV_CODE_W-1:0] dev_code,
    output logic [ADDR_W-1:0]     addr
);
    logic [ADDR_W-1:0] stepped;

    // Next address: wrap inside the page for page devices.
    always_comb begin
        case (dev_code)
            DEV_PAGE4: stepped = {addr[ADDR_W-1:2], addr[1:0] + 2'd1};
            DEV_PAGE8: stepped = {addr[ADDR_W-1:3], addr[2:0] + 3'd1};
            default:   stepped = addr + 1'b1;
        endcase
    end

    // Capture the start address or advance at a beat boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= load_addr;
        else if (step)
            addr <= stepped;
    end
endmodule

// File: rtl/rom_bus_recovery.sv
// Tracks the bus-release gap after an access and decides if a request may start.
// Assumes arm pulses once at the end of each access; same-space requests skip the gap.
module rom_bus_recovery #(
    parameter int CS_W  = 2,
    parameter int REC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [CS_W-1:0]  arm_cs,
    input  logic [REC_W-1:0] arm_cnt,
    input  logic [CS_W-1:0]  req_cs,
    output logic             clear
);
    logic [REC_W-1:0] gap_q;
    logic [CS_W-1:0]  owner_q;

    // Start the gap at the end of an access and drain it one per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q   <= '0;
            owner_q <= '0;
        end else if (arm) begin
            gap_q   <= arm_cnt;
            owner_q <= arm_cs;
        end else if (gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end
    end

    assign clear = (gap_q == '0) || (req_cs == owner_q);
endmodule

// File: rtl/rom_read_seq.sv
// ROM read sequencer top: accepts a request, latches the slot of the target space,
// times each beat, drives address/selects/output enable and pulses done.
// Assumes req_cs < NCS and BEAT_W >= 3 so page position bits exist.
module rom_read_seq
    import rom_seq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LAT_W  = 5,
    parameter int REC_W  = 4,
    parameter int NCS    = 4,
    parameter int BEAT_W = 4,
    localparam int CS_W  = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [BEAT_W-1:0]          req_beats,
    input  logic [CS_W-1:0]            req_cs,
    input  logic [NCS*LAT_W-1:0]       cfg_first_lat,
    input  logic [NCS*LAT_W-1:0]       cfg_burst_lat,
    input  logic [NCS*REC_W-1:0]       cfg_recover,
    input  logic [NCS*DEV_CODE_W-1:0]  cfg_dev_type,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [NCS-1:0]             mem_cs_n,
    output logic                       mem_oe_n,
    output logic                       cap_stb,
    output logic                       done
);
    logic                  busy_q, done_q;
    logic [CS_W-1:0]       cs_q;
    logic [LAT_W-1:0]      first_q, burst_q;
    logic [REC_W-1:0]      rec_q;
    logic [DEV_CODE_W-1:0] dev_q;
    logic [BEAT_W-1:0]     last_idx_q, idx_q;
    logic [BEAT_W-1:0]     idx_next;
    logic                  accept, last_beat, rec_clear;
    logic [LAT_W-1:0]      next_lat;

    assign accept    = req_valid && req_ready;
    assign req_ready = !busy_q && rec_clear;
    assign last_beat = cap_stb && (idx_q == last_idx_q);
    assign idx_next  = idx_q + 1'b1;

    // Wait for the upcoming beat: slot first latency at acceptance, else by page position.
    always_comb begin
        if (accept)
            next_lat = cfg_first_lat[req_cs*LAT_W +: LAT_W];
        else if (opens_page(dev_q, idx_next[2:0]))
            next_lat = first_q;
        else
            next_lat = burst_q;
    end

    // Sample the slot on acceptance and track the beat index until the last strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            done_q     <= 1'b0;
            cs_q       <= '0;
            first_q    <= '0;
            burst_q    <= '0;
            rec_q      <= '0;
            dev_q      <= DEV_PLAIN;
            last_idx_q <= '0;
            idx_q      <= '0;
        end else begin
            done_q <= last_beat;
            if (accept) begin
                busy_q     <= 1'b1;
                cs_q       <= req_cs;
                first_q    <= cfg_first_lat[req_cs*LAT_W +: LAT_W];
                burst_q    <= cfg_burst_lat[req_cs*LAT_W +: LAT_W];
                rec_q      <= cfg_recover[req_cs*REC_W +: REC_W];
                dev_q      <= cfg_dev_type[req_cs*DEV_CODE_W +: DEV_CODE_W];
                last_idx_q <= (req_beats == '0) ? '0 : req_beats - 1'b1;
                idx_q      <= '0;
            end else if (last_beat) begin
                busy_q <= 1'b0;
            end else if (cap_stb) begin
                idx_q <= idx_next;
            end
        end
    end

    rom_beat_timer #(.LAT_W(LAT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy_q),
        .load     (accept || (cap_stb && !last_beat)),
        .load_val (next_lat),
        .stb      (cap_stb)
    );

    rom_addr_step #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_addr (req_addr),
        .step      (cap_stb && !last_beat),
        .dev_code  (dev_q),
        .addr      (mem_addr)
    );

    rom_bus_recovery #(.CS_W(CS_W), .REC_W(REC_W)) u_recovery (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (last_beat),
        .arm_cs  (cs_q),
        .arm_cnt (rec_q),
        .req_cs  (req_cs),
        .clear   (rec_clear)
    );

    // One active-low select per space, low only for the space in use.
    for (genvar g = 0; g < NCS; g++) begin : g_sel
        assign mem_cs_n[g] = !(busy_q && (cs_q == CS_W'(g)));
    end

    assign mem_oe_n = !busy_q;
    assign done     = done_q;
endmodule

// File: rtl/rom_read_seq_checker.sv
// Port-level protocol checks for the ROM read sequencer, bound to every instance.
// Assumes only the top-level ports; it holds no copy of the design state.
module rom_read_seq_checker #(
    parameter int ADDR_W = 24,
    parameter int NCS    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [NCS-1:0]    mem_cs_n,
    input logic              mem_oe_n,
    input logic              cap_stb,
    input logic              done
);
    a_r2_accept_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!mem_oe_n && (mem_cs_n != '1)));

    a_r2_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    a_r2_oe_tracks_select: assert property (@(posedge clk) disable iff (!rst_n)
        mem_oe_n == (mem_cs_n == '1));

    a_r3_strobe_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |-> !mem_oe_n);

    a_r4_addr_held_in_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && !cap_stb) |=> $stable(mem_addr));

    a_r7_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(cap_stb) && mem_oe_n));

    a_r8_busy_blocks_request: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !req_ready);
endmodule

bind rom_read_seq rom_read_seq_checker #(.ADDR_W(ADDR_W), .NCS(NCS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .cap_stb   (cap_stb),
    .done      (done)
);

// File: tb/rom_read_seq_test.sv
// Sweep bench for the ROM read sequencer: every latency pair, several device codes,
// beat counts and spaces; expected timing and addresses are computed arithmetically.
module rom_read_seq_test;
    localparam int ADDR_W = 8;
    localparam int LAT_W  = 3;
    localparam int REC_W  = 3;
    localparam int NCS    = 2;
    localparam int BEAT_W = 4;
    localparam int CS_W   = 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_valid = 1'b0;
    logic                 req_ready;
    logic [ADDR_W-1:0]    req_addr = '0;
    logic [BEAT_W-1:0]    req_beats = '0;
    logic [CS_W-1:0]      req_cs = '0;
    logic [NCS*LAT_W-1:0] cfg_first_lat = '0;
    logic [NCS*LAT_W-1:0] cfg_burst_lat = '0;
    logic [NCS*REC_W-1:0] cfg_recover = '0;
    logic [NCS*3-1:0]     cfg_dev_type = '0;
    logic [ADDR_W-1:0]    mem_addr;
    logic [NCS-1:0]       mem_cs_n;
    logic                 mem_oe_n;
    logic                 cap_stb;
    logic                 done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit prev_valid = 1'b0;
    int prev_cs = 0;
    int prev_rec = 0;

    always #10 clk = ~clk;

    rom_read_seq #(.ADDR_W(ADDR_W), .LAT_W(LAT_W), .REC_W(REC_W),
                   .NCS(NCS), .BEAT_W(BEAT_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_beats(req_beats), .req_cs(req_cs),
        .cfg_first_lat(cfg_first_lat), .cfg_burst_lat(cfg_burst_lat),
        .cfg_recover(cfg_recover), .cfg_dev_type(cfg_dev_type),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .cap_stb(cap_stb), .done(done));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int step_addr(input int a, input int typ);
        if (typ == 2) return (a & 'hFC) | ((a + 1) & 3);
        if (typ == 3) return (a & 'hF8) | ((a + 1) & 7);
        return (a + 1) & 'hFF;
    endfunction

    // One access: program the slot of cs, fill the other slot with junk, check every cycle.
    task automatic do_access(input int cs, input int addr, input int nb_field,
                             input int typ, input int f, input int b, input int r);
        int nb, a, len, waited, exp_wait, strobes;
        bit long_beat;
        string tag;
        logic [NCS-1:0] exp_sel;
        nb = (nb_field == 0) ? 1 : nb_field;
        exp_wait = (prev_valid && cs != prev_cs) ? prev_rec : 0;
        cfg_first_lat = 6'b101_110;
        cfg_burst_lat = 6'b110_101;
        cfg_recover   = 6'b111_111;
        cfg_dev_type  = 6'b011_010;
        cfg_first_lat[cs*LAT_W +: LAT_W] = LAT_W'(f);
        cfg_burst_lat[cs*LAT_W +: LAT_W] = LAT_W'(b);
        cfg_recover[cs*REC_W +: REC_W]   = REC_W'(r);
        cfg_dev_type[cs*3 +: 3]          = 3'(typ);
        req_cs    = CS_W'(cs);
        req_addr  = ADDR_W'(addr);
        req_beats = BEAT_W'(nb_field);
        req_valid = 1'b1;
        waited = 0;
        #1;
        while (!req_ready && waited < 50) begin
            @(negedge clk);
            #1;
            waited++;
        end
        chk(waited == exp_wait, "R8", waited, exp_wait);
        @(posedge clk);
        exp_sel = ~(NCS'(1) << cs);
        a = addr;
        strobes = 0;
        for (int i = 0; i < nb; i++) begin
            if (typ == 2)      long_beat = (i % 4 == 0);
            else if (typ == 3) long_beat = (i % 8 == 0);
            else               long_beat = 1'b1;
            len = long_beat ? f + 1 : b + 1;
            tag = (typ == 2) ? "R5" : (typ == 3) ? "R6" : "R4";
            if (i == 0) tag = (cs == 1) ? "R11" : "R3";
            for (int c = 1; c <= len; c++) begin
                @(negedge clk);
                chk(mem_oe_n == 1'b0, "R2", mem_oe_n, 0);
                chk(mem_cs_n == exp_sel, "R2", mem_cs_n, exp_sel);
                chk(mem_addr == ADDR_W'(a), tag, mem_addr, a);
                chk(cap_stb == (c == len), tag, cap_stb, (c == len));
                chk(done == 1'b0, "R7", done, 0);
                if (cap_stb) strobes++;
                if (i == 0 && c == 1) begin
                    // R9: scramble every configuration field while the access runs.
                    req_valid     = 1'b0;
                    cfg_first_lat = ~cfg_first_lat;
                    cfg_burst_lat = ~cfg_burst_lat;
                    cfg_recover   = ~cfg_recover;
                    cfg_dev_type  = ~cfg_dev_type;
                end
            end
            a = step_addr(a, typ);
        end
        @(negedge clk);
        chk(done == 1'b1, "R7", done, 1);
        chk(mem_oe_n == 1'b1, "R7", mem_oe_n, 1);
        chk(mem_cs_n == '1, "R7", mem_cs_n, 3);
        chk(cap_stb == 1'b0, "R7", cap_stb, 0);
        chk(strobes == nb, (nb_field == 0) ? "R10" : "R9", strobes, nb);
        prev_valid = 1'b1;
        prev_cs    = cs;
        prev_rec   = r;
    endtask

    initial begin
        int k;
        int types[4] = '{0, 2, 3, 5};
        int counts[5] = '{0, 1, 3, 8, 10};
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset.
        chk(mem_cs_n == '1, "R1", mem_cs_n, 3);
        chk(mem_oe_n == 1'b1, "R1", mem_oe_n, 1);
        chk(cap_stb == 1'b0, "R1", cap_stb, 0);
        chk(done == 1'b0, "R1", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", req_ready, 1);
        chk(mem_oe_n == 1'b1, "R1", mem_oe_n, 1);
        k = 0;
        for (int t = 0; t < 4; t++)
            for (int f = 0; f < 4; f++)
                for (int b = 0; b < 4; b++)
                    for (int n = 0; n < 5; n++) begin
                        do_access((k / 3) % 2, (k * 37 + 5) % 256, counts[n],
                                  types[t], f, b, (k * 5) % 8);
                        k++;
                    end
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule